// File: doc/BRIEF.md
# Increment Instruction Decoder

This block classifies the increment operation from an already separated set of instruction fields. It takes the primary opcode byte, the mod, reg and rm fields of the ModRM byte, an optional REX prefix byte with its own valid flag, a LOCK-present flag, an operand-size-override flag and a mode select. The mode select picks between legacy/compatibility mode and 64-bit mode. From these it reports four things:

- whether the bytes form an increment;
- the operand size;
- which register is the destination, or that the destination is in memory;
- whether the combination must raise an invalid-opcode exception.

The block handles three encodings. The byte group opcode with reg field 0 is one. The full-width group opcode with reg field 0 is another. The third is the one-byte short register form, which exists only outside 64-bit mode. In 64-bit mode those short-form bytes are prefixes, so they are not decoded here. When a REX prefix is present, it widens the register index and changes how byte registers 4 to 7 are reached.

The decision logic is purely combinational. A parameter places an optional output register after it, so the block can sit on either side of a pipeline boundary in the front end. Prefix scanning, address generation and memory-protection checks belong to other units.

Top module: `incr_decoder`

## Requirements
- R1: Opcode 8'hFE with ModRM reg field 0 decodes as valid with operand size code 0 (8 bits). The size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits.
- R2: Opcode 8'hFF with ModRM reg field 0 decodes as valid. Its size code is 2 (32 bits) by default, or 1 (16 bits) when the operand-size-override flag is set. This holds in both modes.
- R3: In 64-bit mode, a valid REX byte with bit 3 (W) set gives size code 3 for opcode 8'hFF, even when the override flag is set. In legacy mode the REX inputs are ignored, and the same inputs give size code 2.
- R4: In legacy mode, opcodes 8'h40 to 8'h47 decode as valid with a register destination. The register index is the opcode's low 3 bits with bit 3 zero. The size code is 2, or 1 when the override flag is set.
- R5: In 64-bit mode, opcodes 8'h40 to 8'h47 give every output zero. Valid is low and no exception is raised.
- R6: For the 8'hFE/8'hFF register forms (mod = 2'b11), the register index is the rm field. Bit 3 of the index is REX bit 0 (B) when a REX byte is valid in 64-bit mode, and 0 otherwise.
- R7: The high-byte flag is set for the 8'hFE register form with rm 4 to 7 only when no REX byte is in effect. A valid REX byte in 64-bit mode clears it, so those encodings name the low bytes of registers 4 to 7.
- R8: The LOCK flag on a valid increment with a register destination raises the invalid-opcode flag while valid stays high. The LOCK flag with a memory destination raises nothing.
- R9: A memory destination (mod not 2'b11) sets the memory flag. It forces the register index to 0 and the high-byte flag to 0.
- R10: Opcode 8'hFE/8'hFF with a nonzero reg field, or any other opcode, gives all outputs zero and no exception.
- R11: With the output register enabled (the default), the outputs reflect the inputs one clock later. An active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| opcode | input | 8 | Primary opcode byte |
| modrm_mod | input | 2 | ModRM mod field; 2'b11 means register destination |
| modrm_reg | input | 3 | ModRM reg field (opcode extension) |
| modrm_rm | input | 3 | ModRM rm field (register number for register forms) |
| rex_byte | input | 8 | REX prefix byte (bit 3 W, bit 0 B) |
| rex_vld | input | 1 | REX byte is present |
| lock_pfx | input | 1 | LOCK prefix present |
| opsize_ovr | input | 1 | Operand-size-override prefix present |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy/compatibility mode |
| dec_vld | output | 1 | Bytes form an increment |
| op_size | output | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bits |
| dst_reg | output | 4 | Destination register index |
| dst_mem | output | 1 | Destination is in memory |
| byte_hi | output | 1 | Byte destination is a high-byte register |
| ud_fault | output | 1 | Invalid-opcode exception required |

## Verification
The bench applies the same opcode bytes in both modes. This separates the short form, which decodes in legacy mode and becomes a prefix in 64-bit mode. It also shows that the REX inputs are ignored outside 64-bit mode. Operand size is tested across every combination of the override flag and REX.W, which exposes the priority between them. Register and memory destinations are each run with and without LOCK, which separates a legal locked access from a faulting one. Byte forms with rm 4 to 7 are run with and without REX, which separates the high-byte registers from the extended low-byte registers.

// File: rtl/incr_pkg.sv
package incr_pkg;
    localparam int REG_IDX_W = 4;
    localparam int OPC_W     = 8;

    localparam logic [OPC_W-1:0] OPC_GRP_BYTE = 8'hFE;
    localparam logic [OPC_W-1:0] OPC_GRP_FULL = 8'hFF;
    localparam logic [4:0]       OPC_SHORT_HI = 5'b01000;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } opsz_e;

    typedef enum logic [1:0] {
        FORM_NONE  = 2'd0,
        FORM_BYTE  = 2'd1,
        FORM_FULL  = 2'd2,
        FORM_SHORT = 2'd3
    } form_e;

    typedef struct packed {
        logic                 vld;
        opsz_e                size;
        logic [REG_IDX_W-1:0] reg_idx;
        logic                 mem;
        logic                 hi;
        logic                 ud;
    } dec_t;
endpackage

// File: rtl/incr_opclass.sv
module incr_opclass
    import incr_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [1:0]       modrm_mod,
    input  logic [2:0]       modrm_reg,
    input  logic             mode64,
    output form_e            form,
    output logic             mem_dst
);
    always_comb begin
        form = FORM_NONE;
        if (opcode == OPC_GRP_BYTE && modrm_reg == 3'd0) begin
            form = FORM_BYTE;
        end else if (opcode == OPC_GRP_FULL && modrm_reg == 3'd0) begin
            form = FORM_FULL;
        end else if (opcode[OPC_W-1:3] == OPC_SHORT_HI && !mode64) begin
            form = FORM_SHORT;
        end
        mem_dst = (form == FORM_BYTE || form == FORM_FULL) && (modrm_mod != 2'b11);
    end
endmodule

// File: rtl/incr_size.sv
module incr_size
    import incr_pkg::*;
(
    input  form_e form,
    input  logic  opsize_ovr,
    input  logic  rex_w,
    output opsz_e size
);
    always_comb begin
        unique case (form)
            FORM_BYTE:  size = SZ8;
            FORM_FULL:  size = rex_w ? SZ64 : (opsize_ovr ? SZ16 : SZ32);
            FORM_SHORT: size = opsize_ovr ? SZ16 : SZ32;
            default:    size = SZ8;
        endcase
    end
endmodule

// File: rtl/incr_regsel.sv
module incr_regsel
    import incr_pkg::*;
(
    input  form_e                form,
    input  logic                 mem_dst,
    input  logic [2:0]           opc_low,
    input  logic [2:0]           rm,
    input  logic                 rex_on,
    input  logic                 rex_b,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic                 byte_hi
);
    localparam int PAD_W = REG_IDX_W - 4;

    logic [3:0] idx4;

    always_comb begin
        idx4    = 4'd0;
        byte_hi = 1'b0;
        if (form == FORM_SHORT) begin
            idx4 = {1'b0, opc_low};
        end else if ((form == FORM_BYTE || form == FORM_FULL) && !mem_dst) begin
            idx4 = {rex_on & rex_b, rm};
            byte_hi = (form == FORM_BYTE) && rm[2] && !rex_on;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign reg_idx = {{PAD_W{1'b0}}, idx4};
        end else begin : g_nopad
            assign reg_idx = idx4;
        end
    endgenerate
endmodule

// File: rtl/incr_decoder.sv
module incr_decoder
    import incr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [1:0]           modrm_mod,
    input  logic [2:0]           modrm_reg,
    input  logic [2:0]           modrm_rm,
    input  logic [7:0]           rex_byte,
    input  logic                 rex_vld,
    input  logic                 lock_pfx,
    input  logic                 opsize_ovr,
    input  logic                 mode64,
    output logic                 dec_vld,
    output logic [1:0]           op_size,
    output logic [REG_IDX_W-1:0] dst_reg,
    output logic                 dst_mem,
    output logic                 byte_hi,
    output logic                 ud_fault
);
    localparam int REX_W_BIT = 3;
    localparam int REX_B_BIT = 0;

    form_e                form;
    logic                 mem_dst;
    opsz_e                size;
    logic [REG_IDX_W-1:0] reg_idx;
    logic                 hi;
    logic                 rex_on;
    dec_t                 dec_d;
    dec_t                 dec_q;

    assign rex_on = rex_vld & mode64;

    incr_opclass u_class (
        .opcode    (opcode),
        .modrm_mod (modrm_mod),
        .modrm_reg (modrm_reg),
        .mode64    (mode64),
        .form      (form),
        .mem_dst   (mem_dst)
    );

    incr_size u_size (
        .form       (form),
        .opsize_ovr (opsize_ovr),
        .rex_w      (rex_on & rex_byte[REX_W_BIT]),
        .size       (size)
    );

    incr_regsel u_regsel (
        .form    (form),
        .mem_dst (mem_dst),
        .opc_low (opcode[2:0]),
        .rm      (modrm_rm),
        .rex_on  (rex_on),
        .rex_b   (rex_byte[REX_B_BIT]),
        .reg_idx (reg_idx),
        .byte_hi (hi)
    );

    always_comb begin
        dec_d         = '0;
        dec_d.vld     = (form != FORM_NONE);
        dec_d.size    = size;
        dec_d.reg_idx = reg_idx;
        dec_d.mem     = mem_dst;
        dec_d.hi      = hi;
        dec_d.ud      = dec_d.vld && lock_pfx && !mem_dst;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dec_q <= '0;
                end else begin
                    dec_q <= dec_d;
                end
            end
        end else begin : g_comb
            assign dec_q = dec_d;
        end
    endgenerate

    assign dec_vld  = dec_q.vld;
    assign op_size  = dec_q.size;
    assign dst_reg  = dec_q.reg_idx;
    assign dst_mem  = dec_q.mem;
    assign byte_hi  = dec_q.hi;
    assign ud_fault = dec_q.ud;
endmodule

// File: rtl/incr_decoder_chk.sv
module incr_decoder_chk
    import incr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dec_vld,
    input logic [1:0]           op_size,
    input logic [REG_IDX_W-1:0] dst_reg,
    input logic                 dst_mem,
    input logic                 byte_hi,
    input logic                 ud_fault
);
    // R8: a fault only accompanies a valid decode with a register destination
    a_r8_lock_reg_only: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> (dec_vld && !dst_mem));

    // R9: memory destinations carry no register index and no high-byte flag
    a_r9_mem_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
        dst_mem |-> (dst_reg == '0 && !byte_hi && dec_vld));

    // R7: the high-byte flag belongs only to byte operands
    a_r7_hi_is_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_hi |-> (op_size == 2'd0 && dec_vld));

    // R10: a rejected decode leaves every other output quiet
    a_r10_quiet_reject: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> (!ud_fault && !dst_mem && dst_reg == '0 && op_size == 2'd0));
endmodule

bind incr_decoder incr_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_vld  (dec_vld),
    .op_size  (op_size),
    .dst_reg  (dst_reg),
    .dst_mem  (dst_mem),
    .byte_hi  (byte_hi),
    .ud_fault (ud_fault)
);

// File: tb/incr_decoder_tb.sv
module incr_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opcode = '0;
    logic [1:0] modrm_mod = '0;
    logic [2:0] modrm_reg = '0;
    logic [2:0] modrm_rm = '0;
    logic [7:0] rex_byte = '0;
    logic       rex_vld = 1'b0;
    logic       lock_pfx = 1'b0;
    logic       opsize_ovr = 1'b0;
    logic       mode64 = 1'b0;
    logic       dec_vld;
    logic [1:0] op_size;
    logic [3:0] dst_reg;
    logic       dst_mem;
    logic       byte_hi;
    logic       ud_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    incr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .modrm_mod(modrm_mod),
        .modrm_reg(modrm_reg), .modrm_rm(modrm_rm), .rex_byte(rex_byte),
        .rex_vld(rex_vld), .lock_pfx(lock_pfx), .opsize_ovr(opsize_ovr),
        .mode64(mode64), .dec_vld(dec_vld), .op_size(op_size),
        .dst_reg(dst_reg), .dst_mem(dst_mem), .byte_hi(byte_hi),
        .ud_fault(ud_fault)
    );

    // Drive at a falling edge, let one rising edge register it, sample at the next falling edge.
    task automatic apply(input logic [7:0] opc, input logic [1:0] md, input logic [2:0] rg,
                         input logic [2:0] rm, input logic [7:0] rex, input logic rv,
                         input logic lk, input logic osz, input logic m64);
        opcode = opc; modrm_mod = md; modrm_reg = rg; modrm_rm = rm;
        rex_byte = rex; rex_vld = rv; lock_pfx = lk; opsize_ovr = osz; mode64 = m64;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected vector: {vld, size[1:0], reg[3:0], mem, hi, ud}
    task automatic expect_out(input string req, input logic v, input logic [1:0] sz,
                              input logic [3:0] r, input logic m, input logic h, input logic u);
        logic [9:0] exp_v;
        logic [9:0] act_v;
        exp_v = {v, sz, r, m, h, u};
        act_v = {dec_vld, op_size, dst_reg, dst_mem, byte_hi, ud_fault};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act_v, exp_v);
        end
    endtask

    task automatic t_reset;
        expect_out("R11 reset", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_byte_form;
        apply(8'hFE, 2'b11, 3'd0, 3'd2, 8'h00, 0, 0, 0, 0);
        expect_out("R1 byte reg", 1, 0, 4'd2, 0, 0, 0);
        apply(8'hFE, 2'b00, 3'd0, 3'd5, 8'h00, 0, 0, 0, 1);
        expect_out("R1 R9 byte mem", 1, 0, 4'd0, 1, 0, 0);
    endtask

    task automatic t_full_sizes;
        apply(8'hFF, 2'b11, 3'd0, 3'd1, 8'h00, 0, 0, 0, 0);
        expect_out("R2 default 32", 1, 2, 4'd1, 0, 0, 0);
        apply(8'hFF, 2'b11, 3'd0, 3'd1, 8'h00, 0, 0, 1, 1);
        expect_out("R2 override 16", 1, 1, 4'd1, 0, 0, 0);
        apply(8'hFF, 2'b11, 3'd0, 3'd3, 8'h48, 1, 0, 1, 1);
        expect_out("R3 W beats override", 1, 3, 4'd3, 0, 0, 0);
        apply(8'hFF, 2'b11, 3'd0, 3'd3, 8'h49, 1, 0, 0, 0);
        expect_out("R3 R6 legacy ignores REX", 1, 2, 4'd3, 0, 0, 0);
    endtask

    task automatic t_short_form;
        apply(8'h45, 2'b00, 3'd7, 3'd0, 8'h00, 0, 0, 0, 0);
        expect_out("R4 short 32", 1, 2, 4'd5, 0, 0, 0);
        apply(8'h47, 2'b00, 3'd0, 3'd0, 8'h00, 0, 0, 1, 0);
        expect_out("R4 short 16", 1, 1, 4'd7, 0, 0, 0);
        apply(8'h40, 2'b11, 3'd0, 3'd0, 8'h00, 0, 1, 0, 1);
        expect_out("R5 short is prefix in 64", 0, 0, 4'd0, 0, 0, 0);
    endtask

    task automatic t_regsel;
        apply(8'hFF, 2'b11, 3'd0, 3'd6, 8'h41, 1, 0, 0, 1);
        expect_out("R6 REX.B extends", 1, 2, 4'd14, 0, 0, 0);
        apply(8'hFE, 2'b11, 3'd0, 3'd4, 8'h00, 0, 0, 0, 1);
        expect_out("R7 high byte no REX", 1, 0, 4'd4, 0, 1, 0);
        apply(8'hFE, 2'b11, 3'd0, 3'd4, 8'h40, 1, 0, 0, 1);
        expect_out("R7 REX low byte", 1, 0, 4'd4, 0, 0, 0);
        apply(8'hFE, 2'b11, 3'd0, 3'd7, 8'h40, 1, 0, 0, 0);
        expect_out("R7 legacy keeps high byte", 1, 0, 4'd7, 0, 1, 0);
    endtask

    task automatic t_lock;
        apply(8'hFF, 2'b11, 3'd0, 3'd0, 8'h00, 0, 1, 0, 0);
        expect_out("R8 lock reg faults", 1, 2, 4'd0, 0, 0, 1);
        apply(8'h42, 2'b00, 3'd0, 3'd0, 8'h00, 0, 1, 0, 0);
        expect_out("R8 lock short faults", 1, 2, 4'd2, 0, 0, 1);
        apply(8'hFF, 2'b10, 3'd0, 3'd3, 8'h41, 1, 1, 0, 1);
        expect_out("R8 R9 lock mem legal", 1, 2, 4'd0, 1, 0, 0);
    endtask

    task automatic t_reject;
        apply(8'hFE, 2'b11, 3'd1, 3'd4, 8'h00, 0, 1, 0, 0);
        expect_out("R10 FE reg1", 0, 0, 4'd0, 0, 0, 0);
        apply(8'hFF, 2'b00, 3'd6, 3'd2, 8'h48, 1, 1, 1, 1);
        expect_out("R10 FF reg6", 0, 0, 4'd0, 0, 0, 0);
        apply(8'h48, 2'b11, 3'd0, 3'd0, 8'h00, 0, 0, 0, 0);
        expect_out("R10 other opcode", 0, 0, 4'd0, 0, 0, 0);
    endtask

    task automatic t_latency;
        // R11: one cycle after a change the output follows; before it, the old value holds
        apply(8'hFE, 2'b11, 3'd0, 3'd1, 8'h00, 0, 0, 0, 0);
        opcode = 8'h48;
        #1;
        expect_out("R11 holds before edge", 1, 0, 4'd1, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        expect_out("R11 follows after edge", 0, 0, 4'd0, 0, 0, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_byte_form;
        t_full_sizes;
        t_short_form;
        t_regsel;
        t_lock;
        t_reject;
        t_latency;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule